// File: doc/BRIEF.md
# Integer ALU with Carry and Flag Update

This block is the 32-bit integer execution unit of a small RISC core. Each cycle it takes two source operands, a 16-bit immediate and a 5-bit operation code. It returns a result without any clock delay. It also owns two single-bit status registers: a carry bit and a condition flag. These registers change on the rising clock edge, and only when the selected operation writes them.

The operations are:
- add, add with the stored carry, and subtract;
- the three bitwise logic operations;
- three shifts;
- loading the immediate into the upper half of the word;
- byte, half-word and word extension;
- a conditional select driven by the flag;
- a find-first-one count.

A separate group of ten compares writes only the flag. Parameter `ARITH_FLAG_EN` chooses whether add, add-with-carry and AND also set the flag from a zero result.

Top module: `int_alu_unit`

## Requirements
- R1: While rst_ni is low, flag_o and carry_o are 0.
- R2: Opcode 0 (add) gives result a_i+b_i modulo 2^32. At the next edge, carry_o becomes 1 exactly when that result is less than a_i, compared unsigned.
- R3: Opcode 1 (add with carry) gives a_i+b_i+carry_o modulo 2^32, using the stored carry. Carry updates by the same result-less-than-a_i rule. So a_i=5, b_i=32'hFFFFFFFF with carry set gives 5 and clears carry.
- R4: With ARITH_FLAG_EN=1, opcodes 0, 1 and 3 load the flag with (result==0). With ARITH_FLAG_EN=0, they leave the flag unchanged.
- R5: Opcode 2 gives a_i-b_i, opcode 3 gives a_i&b_i, opcode 4 gives a_i|b_i and opcode 5 gives a_i^b_i. None of them changes carry.
- R6: Opcode 6 shifts a_i left, opcode 7 shifts it right logically and opcode 8 shifts it right arithmetically. The shift amount is b_i[4:0]; the other bits of b_i have no effect.
- R7: Opcode 9 gives {imm_i, 16'h0000}.
- R8: Extension opcodes work on a_i:
  - opcode 10 sign-extends a_i[7:0] and opcode 11 zero-extends it;
  - opcode 12 sign-extends a_i[15:0] and opcode 13 zero-extends it;
  - opcode 14 passes a_i unchanged.
- R9: Opcode 15 gives a_i when the stored flag is 1 and b_i when it is 0.
- R10: Opcode 16 gives the 1-based bit index of the lowest set bit of a_i, or 0 when a_i is 0.
- R11: Opcodes 17 to 26 compare a_i with b_i and load the flag with the outcome. Their result is 0 and they leave carry unchanged. The tests, in opcode order, are:
  - equal and not equal;
  - signed greater, signed greater-or-equal, signed less and signed less-or-equal;
  - unsigned greater, unsigned greater-or-equal, unsigned less and unsigned less-or-equal.
- R12: Opcodes 27 to 31 give result 0. They leave both flag and carry unchanged. Every opcode other than 0 and 1 leaves carry unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock, rising edge |
| rst_ni | input | 1 | Asynchronous reset, active low |
| op_i | input | 5 | Operation code |
| a_i | input | 32 | First source operand |
| b_i | input | 32 | Second source operand |
| imm_i | input | 16 | Immediate for the upper-half load |
| result_o | output | 32 | Combinational result |
| flag_o | output | 1 | Stored condition flag |
| carry_o | output | 1 | Stored carry bit |

## Verification
The bench builds two copies of the unit with the default 32-bit width. One has ARITH_FLAG_EN=1 and the other has ARITH_FLAG_EN=0, and both get the same stimulus. Running both side by side covers both branches of R4, because a zero add or AND result must set the flag in one copy and leave it alone in the other. The fixed width puts the carry wrap corners within reach of directed vectors:
- an all-ones add;
- add-with-carry with b equal to all ones;
- a shift amount above 31;
- a signed versus unsigned compare of 32'h80000000.

// File: rtl/int_alu_pkg.sv
package int_alu_pkg;
  localparam int unsigned OP_W = 5;

  typedef enum logic [OP_W-1:0] {
    OP_ADD   = 5'd0,
    OP_ADDC  = 5'd1,
    OP_SUB   = 5'd2,
    OP_AND   = 5'd3,
    OP_OR    = 5'd4,
    OP_XOR   = 5'd5,
    OP_SLL   = 5'd6,
    OP_SRL   = 5'd7,
    OP_SRA   = 5'd8,
    OP_MOVHI = 5'd9,
    OP_EXTBS = 5'd10,
    OP_EXTBZ = 5'd11,
    OP_EXTHS = 5'd12,
    OP_EXTHZ = 5'd13,
    OP_EXTW  = 5'd14,
    OP_CMOV  = 5'd15,
    OP_FF1   = 5'd16,
    OP_SFEQ  = 5'd17,
    OP_SFNE  = 5'd18,
    OP_SFGTS = 5'd19,
    OP_SFGES = 5'd20,
    OP_SFLTS = 5'd21,
    OP_SFLES = 5'd22,
    OP_SFGTU = 5'd23,
    OP_SFGEU = 5'd24,
    OP_SFLTU = 5'd25,
    OP_SFLEU = 5'd26
  } alu_op_e;

  typedef enum logic [1:0] {
    SH_LL = 2'd0,
    SH_RL = 2'd1,
    SH_RA = 2'd2
  } shift_mode_e;

  typedef enum logic [1:0] {
    EXT_BYTE = 2'd0,
    EXT_HALF = 2'd1,
    EXT_WORD = 2'd2
  } ext_size_e;
endpackage

// File: rtl/alu_addsub.sv
module alu_addsub #(
  parameter int unsigned DATA_W = 32
) (
  input  logic [DATA_W-1:0] a_i,
  input  logic [DATA_W-1:0] b_i,
  input  logic              cin_i,
  input  logic              use_cin_i,
  input  logic              sub_i,
  output logic [DATA_W-1:0] sum_o,
  output logic              carry_o
);
  logic [DATA_W-1:0] inc;

  assign inc   = {{(DATA_W-1){1'b0}}, use_cin_i & cin_i};
  assign sum_o = sub_i ? (a_i - b_i) : (a_i + b_i + inc);
  // carry is defined by unsigned wrap against the first addend
  assign carry_o = (sum_o < a_i);
endmodule

// File: rtl/alu_shift.sv
module alu_shift
  import int_alu_pkg::*;
#(
  parameter int unsigned DATA_W = 32,
  localparam int unsigned SH_W  = $clog2(DATA_W)
) (
  input  logic [DATA_W-1:0] a_i,
  input  logic [SH_W-1:0]   amt_i,
  input  shift_mode_e       mode_i,
  output logic [DATA_W-1:0] res_o
);
  always_comb begin
    unique case (mode_i)
      SH_LL:   res_o = a_i << amt_i;
      SH_RL:   res_o = a_i >> amt_i;
      SH_RA:   res_o = DATA_W'($signed(a_i) >>> amt_i);
      default: res_o = '0;
    endcase
  end
endmodule

// File: rtl/alu_compare.sv
module alu_compare
  import int_alu_pkg::*;
#(
  parameter int unsigned DATA_W = 32
) (
  input  logic [DATA_W-1:0] a_i,
  input  logic [DATA_W-1:0] b_i,
  input  alu_op_e           op_i,
  output logic              hit_o
);
  logic eq, lt_s, lt_u;

  assign eq   = (a_i == b_i);
  assign lt_s = ($signed(a_i) < $signed(b_i));
  assign lt_u = (a_i < b_i);

  always_comb begin
    unique case (op_i)
      OP_SFEQ:  hit_o = eq;
      OP_SFNE:  hit_o = !eq;
      OP_SFGTS: hit_o = !lt_s && !eq;
      OP_SFGES: hit_o = !lt_s;
      OP_SFLTS: hit_o = lt_s;
      OP_SFLES: hit_o = lt_s || eq;
      OP_SFGTU: hit_o = !lt_u && !eq;
      OP_SFGEU: hit_o = !lt_u;
      OP_SFLTU: hit_o = lt_u;
      OP_SFLEU: hit_o = lt_u || eq;
      default:  hit_o = 1'b0;
    endcase
  end
endmodule

// File: rtl/alu_bitops.sv
module alu_bitops
  import int_alu_pkg::*;
#(
  parameter int unsigned DATA_W = 32
) (
  input  logic [DATA_W-1:0] a_i,
  input  ext_size_e         size_i,
  input  logic              sign_i,
  output logic [DATA_W-1:0] ext_o,
  output logic [DATA_W-1:0] ff1_o
);
  always_comb begin
    unique case (size_i)
      EXT_BYTE: ext_o = {{(DATA_W-8){sign_i & a_i[7]}}, a_i[7:0]};
      EXT_HALF: ext_o = {{(DATA_W-16){sign_i & a_i[15]}}, a_i[15:0]};
      default:  ext_o = a_i;
    endcase
  end

  // scan from the top so the lowest set bit wins
  always_comb begin
    ff1_o = '0;
    for (int i = DATA_W - 1; i >= 0; i--) begin
      if (a_i[i]) ff1_o = DATA_W'(i + 1);
    end
  end
endmodule

// File: rtl/int_alu_unit.sv
module int_alu_unit
  import int_alu_pkg::*;
#(
  parameter int unsigned DATA_W        = 32,
  parameter bit          ARITH_FLAG_EN = 1'b1,
  localparam int unsigned IMM_W        = DATA_W / 2,
  localparam int unsigned SH_W         = $clog2(DATA_W)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [OP_W-1:0]   op_i,
  input  logic [DATA_W-1:0] a_i,
  input  logic [DATA_W-1:0] b_i,
  input  logic [IMM_W-1:0]  imm_i,
  output logic [DATA_W-1:0] result_o,
  output logic              flag_o,
  output logic              carry_o
);
  alu_op_e           op;
  logic              flag_q, carry_q;
  logic              flag_we, flag_nxt, carry_we, carry_nxt;
  logic [DATA_W-1:0] sum, sh_res, ext_res, ff1_res, res;
  logic              add_cy, cmp_hit;
  shift_mode_e       sh_mode;
  ext_size_e         ext_size;
  logic              ext_sign;

  assign op = alu_op_e'(op_i);

  alu_addsub #(.DATA_W(DATA_W)) u_addsub (
    .a_i      (a_i),
    .b_i      (b_i),
    .cin_i    (carry_q),
    .use_cin_i(op == OP_ADDC),
    .sub_i    (op == OP_SUB),
    .sum_o    (sum),
    .carry_o  (add_cy)
  );

  always_comb begin
    unique case (op)
      OP_SRL:  sh_mode = SH_RL;
      OP_SRA:  sh_mode = SH_RA;
      default: sh_mode = SH_LL;
    endcase
  end

  alu_shift #(.DATA_W(DATA_W)) u_shift (
    .a_i   (a_i),
    .amt_i (b_i[SH_W-1:0]),
    .mode_i(sh_mode),
    .res_o (sh_res)
  );

  alu_compare #(.DATA_W(DATA_W)) u_cmp (
    .a_i  (a_i),
    .b_i  (b_i),
    .op_i (op),
    .hit_o(cmp_hit)
  );

  always_comb begin
    unique case (op)
      OP_EXTBS, OP_EXTBZ: ext_size = EXT_BYTE;
      OP_EXTHS, OP_EXTHZ: ext_size = EXT_HALF;
      default:            ext_size = EXT_WORD;
    endcase
    ext_sign = (op == OP_EXTBS) || (op == OP_EXTHS);
  end

  alu_bitops #(.DATA_W(DATA_W)) u_bitops (
    .a_i   (a_i),
    .size_i(ext_size),
    .sign_i(ext_sign),
    .ext_o (ext_res),
    .ff1_o (ff1_res)
  );

  always_comb begin
    res       = '0;
    flag_we   = 1'b0;
    flag_nxt  = flag_q;
    carry_we  = 1'b0;
    carry_nxt = carry_q;
    unique case (op)
      OP_ADD, OP_ADDC: begin
        res       = sum;
        carry_we  = 1'b1;
        carry_nxt = add_cy;
        if (ARITH_FLAG_EN) begin
          flag_we  = 1'b1;
          flag_nxt = (sum == '0);
        end
      end
      OP_SUB: res = sum;
      OP_AND: begin
        res = a_i & b_i;
        if (ARITH_FLAG_EN) begin
          flag_we  = 1'b1;
          flag_nxt = ((a_i & b_i) == '0);
        end
      end
      OP_OR:   res = a_i | b_i;
      OP_XOR:  res = a_i ^ b_i;
      OP_SLL, OP_SRL, OP_SRA: res = sh_res;
      OP_MOVHI: res = {imm_i, {(DATA_W-IMM_W){1'b0}}};
      OP_EXTBS, OP_EXTBZ, OP_EXTHS, OP_EXTHZ, OP_EXTW: res = ext_res;
      OP_CMOV: res = flag_q ? a_i : b_i;
      OP_FF1:  res = ff1_res;
      OP_SFEQ, OP_SFNE, OP_SFGTS, OP_SFGES, OP_SFLTS,
      OP_SFLES, OP_SFGTU, OP_SFGEU, OP_SFLTU, OP_SFLEU: begin
        flag_we  = 1'b1;
        flag_nxt = cmp_hit;
      end
      default: res = '0;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      flag_q  <= 1'b0;
      carry_q <= 1'b0;
    end else begin
      if (flag_we)  flag_q  <= flag_nxt;
      if (carry_we) carry_q <= carry_nxt;
    end
  end

  assign result_o = res;
  assign flag_o   = flag_q;
  assign carry_o  = carry_q;
endmodule

// File: rtl/int_alu_chk.sv
module int_alu_chk
  import int_alu_pkg::*;
#(
  parameter int unsigned DATA_W = 32,
  localparam int unsigned IMM_W = DATA_W / 2
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic [OP_W-1:0]   op_i,
  input logic [DATA_W-1:0] a_i,
  input logic [DATA_W-1:0] b_i,
  input logic [IMM_W-1:0]  imm_i,
  input logic [DATA_W-1:0] result_o,
  input logic              flag_o,
  input logic              carry_o
);
  AST_ADD_CARRY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (op_i == OP_ADD) |=> (carry_o == ($past(result_o) < $past(a_i)))); // R2

  AST_MOVHI_LOW: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (op_i == OP_MOVHI) |-> (result_o == {imm_i, {(DATA_W-IMM_W){1'b0}}})); // R7

  AST_CMOV_SEL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (op_i == OP_CMOV) |-> (result_o == (flag_o ? a_i : b_i))); // R9

  AST_FF1_ZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (op_i == OP_FF1 && a_i == '0) |-> (result_o == '0)); // R10

  AST_SFEQ_FLAG: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (op_i == OP_SFEQ) |=> (flag_o == ($past(a_i) == $past(b_i)))); // R11

  AST_CARRY_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (op_i != OP_ADD && op_i != OP_ADDC) |=> $stable(carry_o)); // R12

  AST_SPARE_OP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (op_i > 5'd26) |=> $stable(flag_o)); // R12
endmodule

bind int_alu_unit int_alu_chk #(.DATA_W(DATA_W)) u_chk (.*);

// File: tb/int_alu_unit_tb_top.sv
module int_alu_unit_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [4:0]  op = '0;
  logic [31:0] a = '0, b = '0;
  logic [15:0] imm = '0;
  logic [31:0] res_f, res_n;
  logic        flag_f, carry_f, flag_n, carry_n;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  // model state: f = flag option on, n = flag option off
  logic mf_flag = 1'b0, mf_carry = 1'b0, mn_flag = 1'b0, mn_carry = 1'b0;

  always #4 clk = ~clk;

  int_alu_unit #(.DATA_W(32), .ARITH_FLAG_EN(1'b1)) dut_i (
    .clk_i(clk), .rst_ni(rst_n), .op_i(op), .a_i(a), .b_i(b), .imm_i(imm),
    .result_o(res_f), .flag_o(flag_f), .carry_o(carry_f)
  );

  int_alu_unit #(.DATA_W(32), .ARITH_FLAG_EN(1'b0)) dut_nf_i (
    .clk_i(clk), .rst_ni(rst_n), .op_i(op), .a_i(a), .b_i(b), .imm_i(imm),
    .result_o(res_n), .flag_o(flag_n), .carry_o(carry_n)
  );

  function automatic string req_of(input logic [4:0] o);
    if (o == 0) return "R2";
    if (o == 1) return "R3";
    if (o <= 5) return "R5";
    if (o <= 8) return "R6";
    if (o == 9) return "R7";
    if (o <= 14) return "R8";
    if (o == 15) return "R9";
    if (o == 16) return "R10";
    if (o <= 26) return "R11";
    return "R12";
  endfunction

  function automatic void model(input logic [4:0] o, input logic [31:0] x, y,
                                input logic [15:0] im, input logic f, c, input bit en,
                                output logic [31:0] r, output logic nf, nc);
    r = '0; nf = f; nc = c;
    case (o)
      0: begin r = x + y; nc = (r < x); if (en) nf = (r == 0); end
      1: begin r = x + y + {31'b0, c}; nc = (r < x); if (en) nf = (r == 0); end
      2: r = x - y;
      3: begin r = x & y; if (en) nf = (r == 0); end
      4: r = x | y;
      5: r = x ^ y;
      6: r = x << y[4:0];
      7: r = x >> y[4:0];
      8: r = $signed(x) >>> y[4:0];
      9: r = {im, 16'h0};
      10: r = {{24{x[7]}}, x[7:0]};
      11: r = {24'h0, x[7:0]};
      12: r = {{16{x[15]}}, x[15:0]};
      13: r = {16'h0, x[15:0]};
      14: r = x;
      15: r = f ? x : y;
      16: begin
        for (int i = 0; i < 32; i++) if (x[i]) begin r = i + 1; break; end
      end
      17: nf = (x == y);
      18: nf = (x != y);
      19: nf = ($signed(x) > $signed(y));
      20: nf = ($signed(x) >= $signed(y));
      21: nf = ($signed(x) < $signed(y));
      22: nf = ($signed(x) <= $signed(y));
      23: nf = (x > y);
      24: nf = (x >= y);
      25: nf = (x < y);
      26: nf = (x <= y);
      default: ;
    endcase
  endfunction

  task automatic chk(input string req, input string what, input logic [31:0] act, exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  task automatic step(input logic [4:0] o, input logic [31:0] x, y, input logic [15:0] im);
    logic [31:0] rf, rn;
    logic ff, cf, fn, cn;
    @(negedge clk);
    op = o; a = x; b = y; imm = im;
    model(o, x, y, im, mf_flag, mf_carry, 1'b1, rf, ff, cf);
    model(o, x, y, im, mn_flag, mn_carry, 1'b0, rn, fn, cn);
    #1;
    chk(req_of(o), "result", res_f, rf);
    chk(req_of(o), "result nf", res_n, rn);
    @(posedge clk);
    #1;
    mf_flag = ff; mf_carry = cf; mn_flag = fn; mn_carry = cn;
    chk(req_of(o), "flag", {31'b0, flag_f}, {31'b0, ff});
    chk(req_of(o), "carry", {31'b0, carry_f}, {31'b0, cf});
    chk((o <= 1 || o == 3) ? "R4" : req_of(o), "flag nf", {31'b0, flag_n}, {31'b0, fn});
    chk(req_of(o), "carry nf", {31'b0, carry_n}, {31'b0, cn});
  endtask

  function automatic logic [31:0] pick();
    case ($urandom_range(0, 5))
      0: return 32'h0;
      1: return 32'hFFFF_FFFF;
      2: return 32'h8000_0000;
      3: return 32'h0000_0001;
      default: return $urandom();
    endcase
  endfunction

  initial begin
    #(8 * 150000);
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'h5eed_1234));
    repeat (3) @(posedge clk);
    #1;
    chk("R1", "flag in reset", {31'b0, flag_f}, 32'h0);
    chk("R1", "carry in reset", {31'b0, carry_f}, 32'h0);
    @(negedge clk);
    rst_n = 1'b1;

    // directed corners
    step(5'd0, 32'hFFFF_FFFF, 32'h1, 16'h0);     // R2 wrap: 0, carry 1, flag 1
    step(5'd1, 32'h5, 32'hFFFF_FFFF, 16'h0);     // R3 carry-in with all-ones b
    step(5'd1, 32'h10, 32'h20, 16'h0);           // R3 carry clear
    step(5'd3, 32'hF0F0_0000, 32'h0F0F_FFFF, 16'h0); // R4 AND zero
    step(5'd2, 32'h0, 32'h1, 16'h0);             // R5 borrow, carry untouched
    step(5'd9, 32'hDEAD_BEEF, 32'h0, 16'hA5C3);  // R7
    step(5'd16, 32'h0, 32'h0, 16'h0);            // R10 zero input
    step(5'd16, 32'h8000_0000, 32'h0, 16'h0);    // R10 top bit
    step(5'd16, 32'h0000_0001, 32'h0, 16'h0);    // R10 bottom bit
    step(5'd8, 32'h8000_0000, 32'd31, 16'h0);    // R6 sign fill
    step(5'd6, 32'h1, 32'd33, 16'h0);            // R6 amount masked to 1
    step(5'd7, 32'h8000_0000, 32'hFFFF_FFE4, 16'h0); // R6 amount 4
    step(5'd10, 32'h0000_0080, 32'h0, 16'h0);    // R8
    step(5'd13, 32'hFFFF_8001, 32'h0, 16'h0);    // R8
    step(5'd21, 32'h8000_0000, 32'h1, 16'h0);    // R11 signed less: 1
    step(5'd15, 32'h1111_1111, 32'h2222_2222, 16'h0); // R9 flag set
    step(5'd25, 32'h8000_0000, 32'h1, 16'h0);    // R11 unsigned less: 0
    step(5'd15, 32'h1111_1111, 32'h2222_2222, 16'h0); // R9 flag clear
    step(5'd0, 32'hFFFF_FFFF, 32'h1, 16'h0);
    for (int k = 27; k < 32; k++) step(5'(k), 32'hFFFF_FFFF, 32'h1, 16'hFFFF); // R12

    for (int n = 0; n < 3000; n++)
      step(5'($urandom_range(0, 31)), pick(), pick(), 16'($urandom()));

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule